// File: doc/BRIEF.md
# H-Bridge Switch Driver with Dead-Time Insertion

This block turns a requested bridge mode (charge, slow decay or fast decay) and a current-direction bit into the four gate enables of one full bridge. The bridge has two legs, A and B. Each leg has one high-side switch and one low-side switch. The mapping from mode to switches depends on the direction. Slow decay always closes both low sides.

Whenever the applied mode or direction changes, the block first opens all four switches for a fixed number of clock cycles. Only after that does it close the new set. The cycle count is derived from a time in nanoseconds and the clock period.

Two inputs force all switches open and take priority over any request: a low enable and a latched over-temperature fault. The fault latch has separate trip and clear inputs, which model a sensor with hysteresis. While the fault is latched, an active-low protect output is driven low. When the enable returns or the fault clears, the bridge goes through a full blanking interval before it takes up the requested mode again.

Top module: `hb_bridge_driver`

## Requirements
- R1: While reset is high, and on the first cycle after it, all four switch outputs are 0 and `prot_n` is 1.
- R2: Mode codes are 0 charge, 1 slow decay, 2 fast decay and 3 off. Outputs are listed here as {hi_a,hi_b,lo_a,lo_b}. With `dir_rev`=0, charge gives 1001, slow gives 0011 and fast gives 0110.
- R3: With `dir_rev`=1, charge gives 0110, slow gives 0011 and fast gives 1001.
- R4: Mode code 3 opens all switches from the first clock edge after it is requested, whatever the value of `dir_rev`.
- R5: Suppose the applied mode/direction pair is not off and the request changes to a different pair. Then all switches are 0 for exactly DEAD_CYC cycles, and the new pattern appears on the following edge. This holds even when old and new patterns are equal.
- R6: Suppose the bridge is off and no blanking interval is pending. Then a new request shows its pattern one clock edge after it is presented.
- R7: If `en` is 0 at a clock edge, all switches are 0 after that edge.
- R8: `ot_trip` at an edge latches the fault. `prot_n` is 0 after that edge, and the switches are 0 one edge later. The fault stays latched after `ot_trip` falls.
- R9: `ot_clear` releases the fault at the next edge (`prot_n` back to 1) only when `ot_trip` is low. A trip in the same cycle wins.
- R10: After the last forced-off edge, the switches stay 0 for DEAD_CYC further edges. The requested pattern appears on the edge after those.
- R11: The high side and low side of the same leg are never on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Bridge enable; 0 forces all switches off |
| ot_trip | input | 1 | Over-temperature trip event |
| ot_clear | input | 1 | Over-temperature release event |
| mode_req | input | 2 | Requested mode: 0 charge, 1 slow, 2 fast, 3 off |
| dir_rev | input | 1 | Current direction: 0 forward, 1 reverse |
| sw_hi_a | output | 1 | Leg A high-side enable |
| sw_hi_b | output | 1 | Leg B high-side enable |
| sw_lo_a | output | 1 | Leg A low-side enable |
| sw_lo_b | output | 1 | Leg B low-side enable |
| prot_n | output | 1 | Protect flag, low while the thermal fault is latched |

## Verification
The bench builds the driver with a 10 ns clock period and a 40 ns dead time. This gives DEAD_CYC = 4, short enough that the last blanked cycle and the first driven cycle of every interval can be sampled edge by edge. With this setting, each mode change, enable release and fault clear can be followed through its whole blanking window. The window stays long enough that an off-by-one error in the counter is visible as a wrong value on a specific cycle.

// File: rtl/hb_pkg.sv
package hb_pkg;

    typedef enum logic [1:0] {
        BM_CHARGE = 2'd0,
        BM_SLOW   = 2'd1,
        BM_FAST   = 2'd2,
        BM_OFF    = 2'd3
    } bridge_mode_e;

    typedef struct packed {
        bridge_mode_e mode;
        logic         rev;
    } drive_req_t;

    typedef struct packed {
        logic hi_a;
        logic hi_b;
        logic lo_a;
        logic lo_b;
    } sw_set_t;

    localparam sw_set_t    SW_NONE  = '0;
    localparam drive_req_t REQ_IDLE = '{mode: BM_OFF, rev: 1'b0};

    // Dead time in cycles, rounded up, never below one cycle.
    function automatic int unsigned dead_cycles(int unsigned period_ps, int unsigned dead_ns);
        int unsigned c;
        c = (dead_ns * 1000 + period_ps - 1) / period_ps;
        return (c == 0) ? 1 : c;
    endfunction

    // The off request ignores direction so that it compares equal to idle.
    function automatic drive_req_t make_req(logic [1:0] code, logic rev);
        drive_req_t r;
        r.mode = bridge_mode_e'(code);
        r.rev  = (r.mode == BM_OFF) ? 1'b0 : rev;
        return r;
    endfunction

    function automatic sw_set_t decode(drive_req_t r);
        sw_set_t s;
        s = SW_NONE;
        case (r.mode)
            BM_CHARGE: begin
                s.hi_a = !r.rev; s.lo_b = !r.rev;
                s.hi_b =  r.rev; s.lo_a =  r.rev;
            end
            BM_SLOW: begin
                s.lo_a = 1'b1; s.lo_b = 1'b1;
            end
            BM_FAST: begin
                s.hi_b = !r.rev; s.lo_a = !r.rev;
                s.hi_a =  r.rev; s.lo_b =  r.rev;
            end
            default: s = SW_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/hb_thermal_flag.sv
module hb_thermal_flag (
    input  logic clk,
    input  logic rst,
    input  logic ot_trip,
    input  logic ot_clear,
    output logic fault
);
    logic fault_q;

    always_ff @(posedge clk) begin
        if (rst)           fault_q <= 1'b0;
        else if (ot_trip)  fault_q <= 1'b1;
        else if (ot_clear) fault_q <= 1'b0;
    end

    assign fault = fault_q;

    // R8
    trip_sets_chk: assert property (@(posedge clk) disable iff (rst)
        ot_trip |=> fault);

    // R9
    clear_releases_chk: assert property (@(posedge clk) disable iff (rst)
        (ot_clear && !ot_trip) |=> !fault);

    // R8
    fault_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (!ot_trip && !ot_clear) |=> $stable(fault));

endmodule

// File: rtl/hb_dead_seq.sv
module hb_dead_seq
    import hb_pkg::*;
#(
    parameter int unsigned DEAD_CYC = 30
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       force_off,
    input  drive_req_t req,
    output sw_set_t    sw
);
    localparam int unsigned CW = $clog2(DEAD_CYC + 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(DEAD_CYC);
    localparam logic [CW-1:0] CNT_LAST = CW'(DEAD_CYC - 1);

    drive_req_t    act_q;
    sw_set_t       sw_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= REQ_IDLE;
            sw_q  <= SW_NONE;
            cnt_q <= CNT_FULL;
        end else if (force_off) begin
            act_q <= REQ_IDLE;
            sw_q  <= SW_NONE;
            cnt_q <= CNT_FULL;
        end else if (act_q != req && act_q.mode != BM_OFF) begin
            act_q <= REQ_IDLE;
            sw_q  <= SW_NONE;
            cnt_q <= CNT_LAST;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end else if (act_q != req) begin
            act_q <= req;
            sw_q  <= decode(req);
        end
    end

    assign sw = sw_q;

    // Checker state: length of the current run of all-off cycles, saturating.
    logic [CW-1:0] zrun_q;
    always_ff @(posedge clk) begin
        if (rst)                zrun_q <= '0;
        else if (sw != SW_NONE) zrun_q <= '0;
        else if (zrun_q != CNT_FULL) zrun_q <= zrun_q + 1'b1;
    end

    // R11
    no_shoot_through_chk: assert property (@(posedge clk) disable iff (rst)
        !(sw.hi_a && sw.lo_a) && !(sw.hi_b && sw.lo_b));

    // R7
    force_off_chk: assert property (@(posedge clk) disable iff (rst)
        force_off |=> (sw == SW_NONE));

    // R5
    no_direct_swap_chk: assert property (@(posedge clk) disable iff (rst)
        (sw != SW_NONE && sw != $past(sw)) |-> ($past(sw) == SW_NONE));

    // R10
    dead_len_chk: assert property (@(posedge clk) disable iff (rst)
        (sw != SW_NONE && $past(sw) == SW_NONE) |-> (zrun_q >= CNT_FULL));

endmodule

// File: rtl/hb_bridge_driver.sv
module hb_bridge_driver
    import hb_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_PS = 10000,
    parameter int unsigned DEAD_NS       = 300
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       ot_trip,
    input  logic       ot_clear,
    input  logic [1:0] mode_req,
    input  logic       dir_rev,
    output logic       sw_hi_a,
    output logic       sw_hi_b,
    output logic       sw_lo_a,
    output logic       sw_lo_b,
    output logic       prot_n
);
    localparam int unsigned DEAD_CYC = dead_cycles(CLK_PERIOD_PS, DEAD_NS);

    logic       fault;
    logic       force_off;
    drive_req_t req;
    sw_set_t    sw;

    hb_thermal_flag u_therm (
        .clk      (clk),
        .rst      (rst),
        .ot_trip  (ot_trip),
        .ot_clear (ot_clear),
        .fault    (fault)
    );

    assign force_off = !en || fault;
    assign req       = make_req(mode_req, dir_rev);

    hb_dead_seq #(.DEAD_CYC(DEAD_CYC)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .force_off (force_off),
        .req       (req),
        .sw        (sw)
    );

    assign sw_hi_a = sw.hi_a;
    assign sw_hi_b = sw.hi_b;
    assign sw_lo_a = sw.lo_a;
    assign sw_lo_b = sw.lo_b;
    assign prot_n  = !fault;

    // R8
    fault_blanks_chk: assert property (@(posedge clk) disable iff (rst)
        !prot_n |=> (!sw_hi_a && !sw_hi_b && !sw_lo_a && !sw_lo_b));

endmodule

// File: tb/hb_bridge_driver_tb.sv
`timescale 1ns/1ps
module hb_bridge_driver_tb;
    localparam int CLK_PERIOD = 10;
    localparam int D = 4;

    logic clk = 1'b0;
    logic rst, en, ot_trip, ot_clear, dir_rev;
    logic [1:0] mode_req;
    logic sw_hi_a, sw_hi_b, sw_lo_a, sw_lo_b, prot_n;

    int checks = 0;
    int errors = 0;
    bit shoot_seen = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hb_bridge_driver #(.CLK_PERIOD_PS(10000), .DEAD_NS(40)) u_dut (
        .clk(clk), .rst(rst), .en(en), .ot_trip(ot_trip), .ot_clear(ot_clear),
        .mode_req(mode_req), .dir_rev(dir_rev),
        .sw_hi_a(sw_hi_a), .sw_hi_b(sw_hi_b), .sw_lo_a(sw_lo_a), .sw_lo_b(sw_lo_b),
        .prot_n(prot_n)
    );

    // Entry: [6:5] mode, [4] reverse, [3:0] expected {hi_a,hi_b,lo_a,lo_b}
    localparam int NV = 10;
    localparam logic [6:0] VEC [NV] = '{
        {2'd0, 1'b0, 4'b1001},
        {2'd1, 1'b0, 4'b0011},
        {2'd2, 1'b0, 4'b0110},
        {2'd0, 1'b1, 4'b0110},
        {2'd1, 1'b1, 4'b0011},
        {2'd2, 1'b1, 4'b1001},
        {2'd1, 1'b0, 4'b0011},
        {2'd3, 1'b1, 4'b0000},
        {2'd2, 1'b0, 4'b0110},
        {2'd3, 1'b0, 4'b0000}
    };

    function automatic logic [3:0] outs();
        return {sw_hi_a, sw_hi_b, sw_lo_a, sw_lo_b};
    endfunction

    task automatic tick(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if ((sw_hi_a && sw_lo_a) || (sw_hi_b && sw_lo_b)) shoot_seen = 1'b1;
        end
    endtask

    task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bit prev_off;
        rst = 1'b1; en = 1'b1; ot_trip = 1'b0; ot_clear = 1'b0;
        mode_req = 2'd3; dir_rev = 1'b0;
        tick(3);
        // R1 reset state
        chk("R1 switches", outs(), 4'b0000);
        chk("R1 prot_n", {3'b0, prot_n}, 4'b0001);
        rst = 1'b0;
        tick(1);
        chk("R1 first cycle", outs(), 4'b0000);
        tick(D + 2);

        prev_off = 1'b1;
        for (int k = 0; k < NV; k++) begin
            string tg;
            mode_req = VEC[k][6:5];
            dir_rev  = VEC[k][4];
            tg = VEC[k][4] ? "R3" : "R2";
            if (prev_off) begin
                tick(1);
                chk("R6 immediate from off", outs(), VEC[k][3:0]);
            end else if (VEC[k][6:5] == 2'd3) begin
                tick(1);
                chk("R4 off code", outs(), 4'b0000);
                tick(D);
                chk("R4 off holds", outs(), 4'b0000);
            end else begin
                tick(1);
                chk("R5 blank start", outs(), 4'b0000);
                tick(D - 1);
                chk("R5 blank last", outs(), 4'b0000);
                tick(1);
                chk(tg, outs(), VEC[k][3:0]);
            end
            tick(2);
            chk({tg, " stable"}, outs(), VEC[k][3:0]);
            prev_off = (VEC[k][6:5] == 2'd3);
        end

        // Enable force-off and re-entry (R7, R10)
        mode_req = 2'd0; dir_rev = 1'b0;
        tick(1);
        chk("R6 charge", outs(), 4'b1001);
        en = 1'b0;
        tick(1);
        chk("R7 enable low", outs(), 4'b0000);
        tick(3);
        chk("R7 enable held", outs(), 4'b0000);
        en = 1'b1;
        tick(D);
        chk("R10 enable blank", outs(), 4'b0000);
        tick(1);
        chk("R10 enable resume", outs(), 4'b1001);

        // Thermal fault (R8, R9, R10)
        ot_trip = 1'b1;
        tick(1);
        chk("R8 prot_n low", {3'b0, prot_n}, 4'b0000);
        ot_trip = 1'b0;
        tick(1);
        chk("R8 switches off", outs(), 4'b0000);
        tick(3);
        chk("R8 latched", {3'b0, prot_n}, 4'b0000);
        ot_trip = 1'b1; ot_clear = 1'b1;
        tick(1);
        chk("R9 trip wins", {3'b0, prot_n}, 4'b0000);
        ot_trip = 1'b0;
        tick(1);
        chk("R9 cleared", {3'b0, prot_n}, 4'b0001);
        ot_clear = 1'b0;
        tick(D);
        chk("R10 fault blank", outs(), 4'b0000);
        tick(1);
        chk("R10 fault resume", outs(), 4'b1001);

        // Reset in mid-run (R1)
        rst = 1'b1;
        tick(1);
        chk("R1 mid-run reset", outs(), 4'b0000);
        rst = 1'b0;
        tick(2);

        // R11 over the whole run
        chk("R11 leg exclusion", {3'b0, shoot_seen}, 4'b0000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule